// File: doc/BRIEF.md
# Directory Controller with Write-Completion Stall

This block keeps the directory state of a small set of memory blocks in a directory-based coherence scheme. Each tracked block is Uncached, Shared, Exclusive or Write-Pending. Requests arrive one per cycle. Each is a read miss, a write miss or a data write-back, and each carries a processor number and a block number. The controller answers with invalidate, fetch and data-reply messages and keeps one sharer bit per processor for every block.

When an owner writes its block back, the block does not go straight to Uncached. It waits in Write-Pending until memory signals that the write has landed. A miss to a waiting block is parked in a one-entry slot for that block. The parked miss is replayed by itself once the write completes. Traffic to every other block keeps flowing. Accesses to one block stay ordered, and accesses to different blocks can overtake each other.

A look-up port shows the state, the sharers and the parked flag of any block. The interconnect and the memory are outside the block.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset every block reads Uncached (state code 0), its sharer set is empty and nothing is parked. All message outputs are 0.
- R2: A read miss (kind 0) to an Uncached or Shared block adds the requester to the sharers and replies to the requester. The block becomes Shared (code 1).
- R3: A write miss (kind 1) to an Uncached or Shared block sends an invalidate to the old sharers other than the requester. The invalidate is raised only if that mask is non-empty. The sharers become only the requester, a reply goes to the requester, and the block becomes Exclusive (code 2). An Exclusive block always has exactly one sharer.
- R4: A write miss to an Exclusive block owned by another processor sends a fetch to the owner and a reply to the requester. The requester becomes the sole sharer and the block stays Exclusive.
- R5: A read miss to an Exclusive block owned by another processor sends a fetch to the owner and a reply to the requester. The block becomes Shared with owner and requester as sharers.
- R6: A write-back (kind 2) from the owner of an Exclusive block sends no message, empties the sharers and moves the block to Write-Pending (code 3). Write-Pending is entered only from Exclusive.
- R7: A read or write miss to a Write-Pending block whose slot is free raises only `held` and is parked. Nothing else changes.
- R8: Requests to other blocks are serviced normally while a block is Write-Pending.
- R9: A miss to a Write-Pending block whose slot is occupied raises only `retry` and is dropped.
- R10: A write-complete for a Write-Pending block moves it to Uncached. A write-complete for a block in any other state is ignored. Write-Pending is left by no other event.
- R11: In the cycle after the completion, the parked request is serviced as if it had just arrived, and its slot is freed. Any external request offered in that cycle gets `retry`.
- R12: A write-back from a non-owner, or to a block that is not Exclusive, changes nothing and sends nothing.
- R13: Message outputs appear one cycle after the request. `out_blk` names the block of a reply, invalidate or fetch, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 none |
| req_pid | input | PID_W | Requesting processor |
| req_blk | input | BLK_W | Target block |
| wr_done | input | 1 | Memory finished a write-back |
| wr_done_blk | input | BLK_W | Block whose write finished |
| look_blk | input | BLK_W | Block shown on the look-up outputs |
| inv_valid | output | 1 | Invalidate message |
| inv_mask | output | NPROC | Processors to invalidate |
| fetch_valid | output | 1 | Fetch message to the owner |
| fetch_pid | output | PID_W | Owner to fetch from |
| reply_valid | output | 1 | Data reply |
| reply_pid | output | PID_W | Reply destination |
| out_blk | output | BLK_W | Block of the message |
| held | output | 1 | Request parked behind a pending write |
| retry | output | 1 | Request refused, must be resent |
| look_state | output | 2 | State code of `look_blk` |
| look_sharers | output | NPROC | Sharer vector of `look_blk` |
| look_pend | output | 1 | `look_blk` has a parked request |

## Verification
One block is walked through every state with every kind of request: read and write misses from new processors, from the owner and from non-owners. This separates the invalidate, fetch and reply choices from each other. While that block waits in Write-Pending, misses from different processors are sent to it and to unrelated blocks. That shows the difference between parking, refusing and servicing. Two timing cases are also tried: a write-complete in the same cycle as traffic to another block, and an external request that collides with a replay. Stray write-backs and stray completions are checked against the look-up port to show that they are ignored.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
   typedef enum logic [1:0] {
      DS_UNC = 2'd0,
      DS_SHR = 2'd1,
      DS_EXC = 2'd2,
      DS_WIP = 2'd3
   } dstate_e;

   typedef enum logic [1:0] {
      RQ_RD   = 2'd0,
      RQ_WR   = 2'd1,
      RQ_WB   = 2'd2,
      RQ_NONE = 2'd3
   } rqkind_e;
endpackage

// File: rtl/coh_dir_entry.sv
module coh_dir_entry
   import coh_dir_pkg::*;
#(
   parameter int NPROC = 4,
   parameter int PID_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  dstate_e          nxt_state,
   input  logic [NPROC-1:0] nxt_sharers,
   input  logic             done,
   input  logic             hold_set,
   input  rqkind_e          hold_kind,
   input  logic [PID_W-1:0] hold_pid,
   input  logic             pend_clr,
   output dstate_e          state,
   output logic [NPROC-1:0] sharers,
   output logic             pend_v,
   output rqkind_e          pend_kind,
   output logic [PID_W-1:0] pend_pid
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= DS_UNC;
         sharers   <= '0;
         pend_v    <= 1'b0;
         pend_kind <= RQ_NONE;
         pend_pid  <= '0;
      end else begin
         if (upd) begin
            state   <= nxt_state;
            sharers <= nxt_sharers;
         end else if (done && state == DS_WIP) begin
            state <= DS_UNC;
         end
         if (hold_set) begin
            pend_v    <= 1'b1;
            pend_kind <= hold_kind;
            pend_pid  <= hold_pid;
         end else if (pend_clr) begin
            pend_v <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/coh_dir_action.sv
module coh_dir_action
   import coh_dir_pkg::*;
#(
   parameter int NPROC = 4,
   parameter int PID_W = 2
) (
   input  dstate_e          state,
   input  logic [NPROC-1:0] sharers,
   input  rqkind_e          kind,
   input  logic [PID_W-1:0] pid,
   output logic             upd,
   output dstate_e          nxt_state,
   output logic [NPROC-1:0] nxt_sharers,
   output logic             hold,
   output logic             inv_v,
   output logic [NPROC-1:0] inv_mask,
   output logic             fetch_v,
   output logic [PID_W-1:0] fetch_pid,
   output logic             reply_v
);
   logic [NPROC-1:0] req_bit;
   logic [PID_W-1:0] owner;

   always_comb begin
      owner = '0;
      for (int i = 0; i < NPROC; i++)
         if (sharers[i]) owner = PID_W'(i);
   end

   always_comb begin
      req_bit     = '0;
      req_bit[pid] = 1'b1;
      upd         = 1'b0;
      nxt_state   = state;
      nxt_sharers = sharers;
      hold        = 1'b0;
      inv_v       = 1'b0;
      inv_mask    = '0;
      fetch_v     = 1'b0;
      fetch_pid   = '0;
      reply_v     = 1'b0;
      unique case (state)
         DS_UNC, DS_SHR: begin
            if (kind == RQ_RD) begin
               upd         = 1'b1;
               nxt_state   = DS_SHR;
               nxt_sharers = sharers | req_bit;
               reply_v     = 1'b1;
            end else if (kind == RQ_WR) begin
               upd         = 1'b1;
               nxt_state   = DS_EXC;
               nxt_sharers = req_bit;
               inv_mask    = sharers & ~req_bit;
               inv_v       = |(sharers & ~req_bit);
               reply_v     = 1'b1;
            end
         end
         DS_EXC: begin
            if (kind == RQ_RD || kind == RQ_WR) begin
               upd       = 1'b1;
               reply_v   = 1'b1;
               fetch_v   = (owner != pid);
               fetch_pid = (owner != pid) ? owner : '0;
               if (kind == RQ_RD) begin
                  nxt_state   = DS_SHR;
                  nxt_sharers = sharers | req_bit;
               end else begin
                  nxt_sharers = req_bit;
               end
            end else if (kind == RQ_WB && owner == pid) begin
               upd         = 1'b1;
               nxt_state   = DS_WIP;
               nxt_sharers = '0;
            end
         end
         DS_WIP: begin
            hold = (kind == RQ_RD || kind == RQ_WR);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/coh_dir_pick.sv
module coh_dir_pick #(
   parameter int NBLK  = 4,
   parameter int BLK_W = 2
) (
   input  logic [NBLK-1:0]  want,
   output logic             go,
   output logic [BLK_W-1:0] idx
);
   always_comb begin
      go  = |want;
      idx = '0;
      for (int i = NBLK - 1; i >= 0; i--)
         if (want[i]) idx = BLK_W'(i);
   end
endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
   import coh_dir_pkg::*;
#(
   parameter int NPROC = 4,
   parameter int NBLK  = 4,
   localparam int PID_W = (NPROC > 1) ? $clog2(NPROC) : 1,
   localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_kind,
   input  logic [PID_W-1:0] req_pid,
   input  logic [BLK_W-1:0] req_blk,
   input  logic             wr_done,
   input  logic [BLK_W-1:0] wr_done_blk,
   input  logic [BLK_W-1:0] look_blk,
   output logic             inv_valid,
   output logic [NPROC-1:0] inv_mask,
   output logic             fetch_valid,
   output logic [PID_W-1:0] fetch_pid,
   output logic             reply_valid,
   output logic [PID_W-1:0] reply_pid,
   output logic [BLK_W-1:0] out_blk,
   output logic             held,
   output logic             retry,
   output logic [1:0]       look_state,
   output logic [NPROC-1:0] look_sharers,
   output logic             look_pend
);
   if (NPROC < 2) begin : g_bad_nproc
      $error("coh_dir_ctrl: NPROC must be at least 2");
   end
   if (NBLK < 1) begin : g_bad_nblk
      $error("coh_dir_ctrl: NBLK must be at least 1");
   end

   dstate_e          st [NBLK];
   logic [NPROC-1:0] sh [NBLK];
   logic             pv [NBLK];
   rqkind_e          pk [NBLK];
   logic [PID_W-1:0] pp [NBLK];
   logic [NBLK-1:0]  want;

   logic             rep_go;
   logic [BLK_W-1:0] rep_idx;

   logic             op_go;
   rqkind_e          op_kind;
   logic [PID_W-1:0] op_pid;
   logic [BLK_W-1:0] op_blk;

   logic             a_upd, a_hold, a_inv, a_fetch, a_reply;
   dstate_e          a_state;
   logic [NPROC-1:0] a_sharers, a_mask;
   logic [PID_W-1:0] a_fpid;
   logic             hold_ok, full_retry, busy_retry;

   for (genvar b = 0; b < NBLK; b++) begin : g_blk
      assign want[b] = pv[b] && (st[b] != DS_WIP);
      coh_dir_entry #(.NPROC(NPROC), .PID_W(PID_W)) u_ent (
         .clk        (clk),
         .rst_n      (rst_n),
         .upd        (op_go && a_upd && op_blk == BLK_W'(b)),
         .nxt_state  (a_state),
         .nxt_sharers(a_sharers),
         .done       (wr_done && wr_done_blk == BLK_W'(b)),
         .hold_set   (hold_ok && op_blk == BLK_W'(b)),
         .hold_kind  (op_kind),
         .hold_pid   (op_pid),
         .pend_clr   (rep_go && rep_idx == BLK_W'(b)),
         .state      (st[b]),
         .sharers    (sh[b]),
         .pend_v     (pv[b]),
         .pend_kind  (pk[b]),
         .pend_pid   (pp[b])
      );
   end

   coh_dir_pick #(.NBLK(NBLK), .BLK_W(BLK_W)) u_pick (
      .want(want),
      .go  (rep_go),
      .idx (rep_idx)
   );

   always_comb begin
      if (rep_go) begin
         op_go   = 1'b1;
         op_kind = pk[rep_idx];
         op_pid  = pp[rep_idx];
         op_blk  = rep_idx;
      end else begin
         op_go   = req_valid && (rqkind_e'(req_kind) != RQ_NONE);
         op_kind = rqkind_e'(req_kind);
         op_pid  = req_pid;
         op_blk  = req_blk;
      end
   end

   coh_dir_action #(.NPROC(NPROC), .PID_W(PID_W)) u_act (
      .state      (st[op_blk]),
      .sharers    (sh[op_blk]),
      .kind       (op_kind),
      .pid        (op_pid),
      .upd        (a_upd),
      .nxt_state  (a_state),
      .nxt_sharers(a_sharers),
      .hold       (a_hold),
      .inv_v      (a_inv),
      .inv_mask   (a_mask),
      .fetch_v    (a_fetch),
      .fetch_pid  (a_fpid),
      .reply_v    (a_reply)
   );

   assign busy_retry = req_valid && rep_go;
   assign hold_ok    = !rep_go && op_go && a_hold && !pv[op_blk];
   assign full_retry = !rep_go && op_go && a_hold && pv[op_blk];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inv_valid   <= 1'b0;
         inv_mask    <= '0;
         fetch_valid <= 1'b0;
         fetch_pid   <= '0;
         reply_valid <= 1'b0;
         reply_pid   <= '0;
         out_blk     <= '0;
         held        <= 1'b0;
         retry       <= 1'b0;
      end else begin
         inv_valid   <= op_go && a_inv;
         inv_mask    <= op_go ? a_mask : '0;
         fetch_valid <= op_go && a_fetch;
         fetch_pid   <= op_go ? a_fpid : '0;
         reply_valid <= op_go && a_reply;
         reply_pid   <= (op_go && a_reply) ? op_pid : '0;
         out_blk     <= (op_go && (a_reply || a_inv || a_fetch)) ? op_blk : '0;
         held        <= hold_ok;
         retry       <= busy_retry || full_retry;
      end
   end

   assign look_state   = st[look_blk];
   assign look_sharers = sh[look_blk];
   assign look_pend    = pv[look_blk];
endmodule

// File: rtl/coh_dir_chk.sv
module coh_dir_chk
   import coh_dir_pkg::*;
#(
   parameter int NPROC = 4,
   parameter int NBLK  = 4,
   localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             rep_go,
   input logic             held,
   input logic             retry,
   input logic             reply_valid,
   input logic             inv_valid,
   input logic             fetch_valid,
   input logic             wr_done,
   input logic [BLK_W-1:0] wr_done_blk,
   input dstate_e          st [NBLK],
   input logic [NPROC-1:0] sh [NBLK]
);
   a_r7_held_alone: assert property (@(posedge clk) disable iff (!rst_n)
      held |-> !(reply_valid || inv_valid || fetch_valid || retry));

   a_r11_busy_retry: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && rep_go) |=> retry);

   for (genvar b = 0; b < NBLK; b++) begin : g_chk
      a_r10_wip_exit: assert property (@(posedge clk) disable iff (!rst_n)
         (st[b] == DS_WIP && !(wr_done && wr_done_blk == BLK_W'(b))) |=> st[b] == DS_WIP);

      a_r6_wip_from_exc: assert property (@(posedge clk) disable iff (!rst_n)
         (st[b] == DS_WIP && $past(st[b]) != DS_WIP) |-> $past(st[b]) == DS_EXC);

      a_r6_wip_no_sharers: assert property (@(posedge clk) disable iff (!rst_n)
         st[b] == DS_WIP |-> sh[b] == '0);

      a_r3_exc_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
         st[b] == DS_EXC |-> $countones(sh[b]) == 1);
   end
endmodule

bind coh_dir_ctrl coh_dir_chk #(.NPROC(NPROC), .NBLK(NBLK)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .rep_go     (rep_go),
   .held       (held),
   .retry      (retry),
   .reply_valid(reply_valid),
   .inv_valid  (inv_valid),
   .fetch_valid(fetch_valid),
   .wr_done    (wr_done),
   .wr_done_blk(wr_done_blk),
   .st         (st),
   .sh         (sh)
);

// File: tb/tb_coh_dir_ctrl.sv
module tb_coh_dir_ctrl;
   localparam logic [1:0] RD = 2'd0, WR = 2'd1, WB = 2'd2;

   typedef struct packed {
      logic       iv;
      logic [3:0] im;
      logic       fv;
      logic [1:0] fp;
      logic       rv;
      logic [1:0] rp;
      logic [1:0] blk;
      logic       hd;
      logic       rt;
   } obs_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_kind = 2'd3;
   logic [1:0] req_pid = '0;
   logic [1:0] req_blk = '0;
   logic       wr_done = 1'b0;
   logic [1:0] wr_done_blk = '0;
   logic [1:0] look_blk = '0;
   logic       inv_valid, fetch_valid, reply_valid, held, retry, look_pend;
   logic [3:0] inv_mask, look_sharers;
   logic [1:0] fetch_pid, reply_pid, out_blk, look_state;

   int checks = 0;
   int fails  = 0;
   obs_t  exp_q[$];
   string tag_q[$];

   always #10 clk = ~clk;

   coh_dir_ctrl #(.NPROC(4), .NBLK(4)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_pid(req_pid), .req_blk(req_blk), .wr_done(wr_done),
      .wr_done_blk(wr_done_blk), .look_blk(look_blk), .inv_valid(inv_valid),
      .inv_mask(inv_mask), .fetch_valid(fetch_valid), .fetch_pid(fetch_pid),
      .reply_valid(reply_valid), .reply_pid(reply_pid), .out_blk(out_blk),
      .held(held), .retry(retry), .look_state(look_state),
      .look_sharers(look_sharers), .look_pend(look_pend)
   );

   function automatic obs_t now_obs();
      return '{inv_valid, inv_mask, fetch_valid, fetch_pid, reply_valid,
               reply_pid, out_blk, held, retry};
   endfunction

   function automatic obs_t rsp(logic iv, logic [3:0] im, logic fv, logic [1:0] fp,
                                logic rv, logic [1:0] rp, logic [1:0] b,
                                logic hd, logic rt);
      return '{iv, im, fv, fp, rv, rp, b, hd, rt};
   endfunction

   // monitor: compares the outputs produced after each clock edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() > 0) begin
            obs_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (now_obs() !== e) begin
               fails++;
               $display("FAIL %s: outputs actual=%h expected=%h", t, now_obs(), e);
            end
         end
      end
   end

   task automatic step(input logic v, input logic [1:0] k, input logic [1:0] p,
                       input logic [1:0] b, input logic d, input logic [1:0] db,
                       input obs_t e, input string t);
      @(negedge clk);
      req_valid = v; req_kind = k; req_pid = p; req_blk = b;
      wr_done = d; wr_done_blk = db;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(posedge clk);
      #2;
      req_valid = 1'b0; req_kind = 2'd3; wr_done = 1'b0;
   endtask

   task automatic look(input logic [1:0] b, input logic [1:0] es,
                       input logic [3:0] esh, input logic ep, input string t);
      look_blk = b;
      #1;
      checks++;
      if (look_state !== es || look_sharers !== esh || look_pend !== ep) begin
         fails++;
         $display("FAIL %s: blk%0d state/sharers/pend actual=%0d/%b/%b expected=%0d/%b/%b",
                  t, b, look_state, look_sharers, look_pend, es, esh, ep);
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      obs_t nil;
      nil = '0;
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      // R1 reset state
      checks++;
      if (now_obs() !== nil) begin
         fails++;
         $display("FAIL R1: outputs actual=%h expected=%h", now_obs(), nil);
      end
      for (int b = 0; b < 4; b++) look(2'(b), 2'd0, 4'b0000, 1'b0, "R1 reset");

      step(1, RD, 2'd0, 2'd0, 0, 2'd0, rsp(0,4'h0,0,2'd0,1,2'd0,2'd0,0,0), "R2 first read");
      look(2'd0, 2'd1, 4'b0001, 1'b0, "R2 first read");
      step(1, RD, 2'd1, 2'd0, 0, 2'd0, rsp(0,4'h0,0,2'd0,1,2'd1,2'd0,0,0), "R2 second read");
      look(2'd0, 2'd1, 4'b0011, 1'b0, "R2 second read");
      step(1, WR, 2'd2, 2'd0, 0, 2'd0, rsp(1,4'b0011,0,2'd0,1,2'd2,2'd0,0,0), "R3 write shared");
      look(2'd0, 2'd2, 4'b0100, 1'b0, "R3 write shared");
      step(1, WR, 2'd3, 2'd0, 0, 2'd0, rsp(0,4'h0,1,2'd2,1,2'd3,2'd0,0,0), "R4 write exclusive");
      look(2'd0, 2'd2, 4'b1000, 1'b0, "R4 write exclusive");
      step(1, RD, 2'd1, 2'd0, 0, 2'd0, rsp(0,4'h0,1,2'd3,1,2'd1,2'd0,0,0), "R5 read exclusive");
      look(2'd0, 2'd1, 4'b1010, 1'b0, "R5 read exclusive");
      step(1, WR, 2'd1, 2'd0, 0, 2'd0, rsp(1,4'b1000,0,2'd0,1,2'd1,2'd0,0,0), "R3 sharer writes");
      look(2'd0, 2'd2, 4'b0010, 1'b0, "R3 sharer writes");
      step(1, WB, 2'd0, 2'd0, 0, 2'd0, nil, "R12 non-owner write-back");
      look(2'd0, 2'd2, 4'b0010, 1'b0, "R12 non-owner write-back");
      step(1, WB, 2'd1, 2'd0, 0, 2'd0, nil, "R6 owner write-back");
      look(2'd0, 2'd3, 4'b0000, 1'b0, "R6 owner write-back");
      step(1, RD, 2'd2, 2'd0, 0, 2'd0, rsp(0,4'h0,0,2'd0,0,2'd0,2'd0,1,0), "R7 read held");
      look(2'd0, 2'd3, 4'b0000, 1'b1, "R7 read held");
      step(1, RD, 2'd0, 2'd1, 0, 2'd0, rsp(0,4'h0,0,2'd0,1,2'd0,2'd1,0,0), "R8 other block");
      look(2'd1, 2'd1, 4'b0001, 1'b0, "R8 other block");
      step(1, RD, 2'd3, 2'd0, 0, 2'd0, rsp(0,4'h0,0,2'd0,0,2'd0,2'd0,0,1), "R9 read slot full");
      step(1, WR, 2'd0, 2'd0, 0, 2'd0, rsp(0,4'h0,0,2'd0,0,2'd0,2'd0,0,1), "R9 write slot full");
      look(2'd0, 2'd3, 4'b0000, 1'b1, "R9 state kept");
      step(0, RD, 2'd0, 2'd0, 1, 2'd1, nil, "R10 stray completion");
      look(2'd1, 2'd1, 4'b0001, 1'b0, "R10 stray completion");
      step(0, RD, 2'd0, 2'd0, 1, 2'd0, nil, "R10 completion");
      look(2'd0, 2'd0, 4'b0000, 1'b1, "R10 completion");
      step(0, RD, 2'd0, 2'd0, 0, 2'd0, rsp(0,4'h0,0,2'd0,1,2'd2,2'd0,0,0), "R11 replay read");
      look(2'd0, 2'd1, 4'b0100, 1'b0, "R11 replay read");
      step(1, WB, 2'd2, 2'd0, 0, 2'd0, nil, "R12 write-back to shared");
      look(2'd0, 2'd1, 4'b0100, 1'b0, "R12 write-back to shared");

      step(1, WR, 2'd0, 2'd2, 0, 2'd0, rsp(0,4'h0,0,2'd0,1,2'd0,2'd2,0,0), "R3 write uncached");
      look(2'd2, 2'd2, 4'b0001, 1'b0, "R3 write uncached");
      step(1, WB, 2'd0, 2'd2, 0, 2'd0, nil, "R6 second write-back");
      look(2'd2, 2'd3, 4'b0000, 1'b0, "R6 second write-back");
      step(1, WR, 2'd3, 2'd2, 0, 2'd0, rsp(0,4'h0,0,2'd0,0,2'd0,2'd0,1,0), "R7 write held");
      step(1, RD, 2'd1, 2'd3, 1, 2'd2, rsp(0,4'h0,0,2'd0,1,2'd1,2'd3,0,0), "R8 service with completion");
      look(2'd2, 2'd0, 4'b0000, 1'b1, "R10 completion with traffic");
      look(2'd3, 2'd1, 4'b0010, 1'b0, "R8 service with completion");
      step(1, RD, 2'd0, 2'd3, 0, 2'd0, rsp(0,4'h0,0,2'd0,1,2'd3,2'd2,0,1), "R11 replay write with collision");
      look(2'd2, 2'd2, 4'b1000, 1'b0, "R11 replay write with collision");
      look(2'd3, 2'd1, 4'b0010, 1'b0, "R11 collided request dropped");
      step(0, RD, 2'd0, 2'd0, 0, 2'd0, nil, "R13 quiet when idle");

      repeat (2) @(posedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule